// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This engine turns one request into the complete bus sequence a small-page NAND device needs to start an operation. A request carries an 8-bit opcode, a column and a page (row) address. The column and the page each come with their own present flag. The block first runs a command phase with the command latch enable high, and then, if any address is present, an address phase with the address latch enable high. Each byte goes out on its own write-strobe pulse, with chip enable low. After the latch phases the block either finishes at once, polls the ready line a bounded number of times, or waits on it without limit. The choice depends on the opcode.

Two cases get special handling. A program-setup request is preceded by an automatically chosen pointer opcode, and its column is rebased to match that pointer. A read request that carries a page address keeps chip enable forced low from the second row byte until the device reports ready or the poll budget runs out. All delays are parameters derived from the clock frequency: the write-to-busy gap, the one-microsecond poll interval and the one-microsecond settle gap after the address phase.

Top module: `nand_cmd_seq`

## Requirements
- R1: `req_ready` is high exactly while the block is idle (and after reset). A request is taken when `req_valid` and `req_ready` are both high, after which `req_ready` stays low until the operation completes.
- R2: Each opcode byte is latched on the rising edge of `nand_we_n`, with `nand_cle`=1, `nand_ale`=0 and `nand_ce_n`=0. The byte is in `nand_dq_out[7:0]` and bits 15:8 are zero.
- R3: For opcode 0x80 (program setup), a pointer opcode is latched first. If the column is present and at or above PAGE_BYTES, the pointer is 0x50 and the column becomes column−PAGE_BYTES. If the column is at or above 256 (and below PAGE_BYTES), the pointer is 0x01 and the column becomes column−256. Otherwise, including when the column is absent, the pointer is 0x00.
- R4: Address bytes are latched with `nand_ale`=1 and `nand_cle`=0, in this order: column bits 7:0 (if present), then page bits 7:0 and page bits 15:8 (if present). When `cfg_row3`=1, a last byte {4'b0, page[19:16]} follows.
- R5: With `cfg_bus16`=1 the column is halved before it is sent, except for opcodes 0x90, 0xEC, 0xEE and 0xEF, which keep byte addressing.
- R6: When neither column nor page is present, no address byte is latched.
- R7: Opcodes 0x10, 0x60, 0xD0, 0x80 and 0x70 complete without looking at `nand_rdy`. Completion comes within a few cycles of the last latch, plus the settle gap when an address phase ran.
- R8: For opcodes 0x00, 0x01 and 0x50 with a page present, `nand_ce_n` stays low from the second row byte through the whole wait and goes high by the completion pulse. Other operations leave `nand_ce_n` high outside strobe slots.
- R9: A read with a page present waits TWB cycles, then samples `nand_rdy` every US_CYC cycles, up to POLL_MAX+1 samples. If ready is seen, the block completes with `timeout`=0. If ready is never seen, it completes with `timeout`=1 about TWB + POLL_MAX·US_CYC cycles after the settle gap.
- R10: Every other opcode, and a read without a page, waits without limit for `nand_rdy`=1 after the TWB gap and never reports a timeout.
- R11: When an address phase ran, at least US_CYC cycles pass between the last address latch and completion or the start of the wait.
- R12: `done` is a one-cycle pulse. `timeout` keeps its value from completion until the next request is accepted, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_opcode | input | 8 | Command opcode |
| req_col | input | COL_W | Column address in bytes |
| req_col_vld | input | 1 | Column present |
| req_page | input | PAGE_W | Page (row) address |
| req_page_vld | input | 1 | Page present |
| cfg_bus16 | input | 1 | Device uses a 16-bit data bus |
| cfg_row3 | input | 1 | Device takes three row bytes |
| nand_rdy | input | 1 | Ready/busy line, high when ready |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, latches on rising edge |
| nand_dq_out | output | 16 | Data bus value, byte zero-extended |
| nand_dq_oe | output | 1 | Data bus drive enable |
| done | output | 1 | Operation complete pulse |
| timeout | output | 1 | Bounded read wait expired without ready |

## Verification
The assertions assume that `cfg_bus16` and `cfg_row3` are stable while an operation is in flight, and that `req_valid` is offered only with fields that are valid for that cycle. Under those assumptions, strobe-to-data alignment and the release of chip enable can be checked against `done`. The stimulus changes the configuration inputs only after a completion pulse and before it offers the next request. It raises `nand_rdy` only during the wait phases whose ready handling is under test. The ready line is held low elsewhere, so completions that must ignore it are seen to do so.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam logic [7:0] OP_READ0       = 8'h00;
  localparam logic [7:0] OP_READ1       = 8'h01;
  localparam logic [7:0] OP_READOOB     = 8'h50;
  localparam logic [7:0] OP_PROG_SETUP  = 8'h80;
  localparam logic [7:0] OP_PROG        = 8'h10;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_STATUS      = 8'h70;

  localparam int SLOTS = 6;

  typedef enum logic [1:0] {
    WAIT_NONE,
    WAIT_BOUNDED,
    WAIT_FOREVER
  } wait_mode_e;

  typedef struct packed {
    logic [SLOTS-1:0][7:0] bytes;
    logic [SLOTS-1:0]      is_addr;
    logic [2:0]            count;
    logic [2:0]            hold_idx;
    logic                  hold_en;
    logic                  has_addr;
    wait_mode_e            mode;
  } seq_plan_t;

  function automatic logic op_is_read(input logic [7:0] op);
    return (op == OP_READ0) || (op == OP_READ1) || (op == OP_READOOB);
  endfunction

  function automatic logic op_no_wait(input logic [7:0] op);
    return (op == OP_PROG) || (op == OP_ERASE_SETUP) || (op == OP_ERASE_GO) ||
           (op == OP_PROG_SETUP) || (op == OP_STATUS);
  endfunction

  // opcodes whose column stays in byte units on a 16-bit bus
  function automatic logic op_byte_addr(input logic [7:0] op);
    return (op == 8'h90) || (op == 8'hEC) || (op == 8'hEE) || (op == 8'hEF);
  endfunction

  // pointer opcode issued ahead of program setup
  function automatic logic [7:0] ptr_select(input logic [31:0] col, input logic col_vld,
                                            input logic [31:0] page_bytes);
    if (!col_vld)                return OP_READ0;
    else if (col >= page_bytes)  return OP_READOOB;
    else if (col >= 32'd256)     return OP_READ1;
    else                         return OP_READ0;
  endfunction

  // final column byte after pointer rebasing and bus-width scaling
  function automatic logic [7:0] col_byte(input logic [31:0] col, input logic [7:0] op,
                                          input logic bus16, input logic [31:0] page_bytes);
    logic [31:0] c;
    c = col;
    if (op == OP_PROG_SETUP) begin
      if (col >= page_bytes)   c = col - page_bytes;
      else if (col >= 32'd256) c = col - 32'd256;
    end
    if (bus16 && !op_byte_addr(op)) c = c >> 1;
    return c[7:0];
  endfunction

endpackage

// File: rtl/nand_seq_plan.sv
module nand_seq_plan
  import nand_seq_pkg::*;
#(
  parameter int COL_W      = 12,
  parameter int PAGE_W     = 20,
  parameter int PAGE_BYTES = 512
) (
  input  logic [7:0]        opcode,
  input  logic [COL_W-1:0]  col,
  input  logic              col_vld,
  input  logic [PAGE_W-1:0] page,
  input  logic              page_vld,
  input  logic              bus16,
  input  logic              row3,
  output seq_plan_t         plan
);

  localparam logic [31:0] PB = 32'(PAGE_BYTES);

  logic [31:0] col_w;
  logic [19:0] row_w;

  assign col_w = 32'(col);
  assign row_w = 20'(page);

  always_comb begin
    logic [2:0] n;
    plan = '0;
    n    = '0;
    if (opcode == OP_PROG_SETUP) begin
      plan.bytes[n] = ptr_select(col_w, col_vld, PB);
      n = n + 3'd1;
    end
    plan.bytes[n] = opcode;
    n = n + 3'd1;
    if (col_vld) begin
      plan.bytes[n]   = col_byte(col_w, opcode, bus16, PB);
      plan.is_addr[n] = 1'b1;
      n = n + 3'd1;
    end
    if (page_vld) begin
      plan.bytes[n]   = row_w[7:0];
      plan.is_addr[n] = 1'b1;
      n = n + 3'd1;
      if (op_is_read(opcode)) begin
        plan.hold_en  = 1'b1;
        plan.hold_idx = n;
      end
      plan.bytes[n]   = row_w[15:8];
      plan.is_addr[n] = 1'b1;
      n = n + 3'd1;
      if (row3) begin
        plan.bytes[n]   = {4'h0, row_w[19:16]};
        plan.is_addr[n] = 1'b1;
        n = n + 3'd1;
      end
    end
    plan.count    = n;
    plan.has_addr = col_vld | page_vld;
    if (op_no_wait(opcode))                  plan.mode = WAIT_NONE;
    else if (op_is_read(opcode) && page_vld) plan.mode = WAIT_BOUNDED;
    else                                     plan.mode = WAIT_FOREVER;
  end

endmodule

// File: rtl/nand_we_strobe.sv
module nand_we_strobe #(
  parameter int STB_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic we_n,
  output logic slot_end,
  output logic active
);

  localparam int SLOT = 2 * STB_CYC;
  localparam int CW   = (SLOT > 2) ? $clog2(SLOT) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == CW'(SLOT - 1)) active <= 1'b0;
      else                      cnt    <= cnt + 1'b1;
    end
  end

  assign we_n     = !(active && (cnt < CW'(STB_CYC)));
  assign slot_end = active && (cnt == CW'(SLOT - 1));

endmodule

// File: rtl/nand_delay_tmr.sv
module nand_delay_tmr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int COL_W      = 12,
  parameter int PAGE_W     = 20,
  parameter int PAGE_BYTES = 512,
  parameter int CLK_MHZ    = 50,
  parameter int TWB_NS     = 100,
  parameter int POLL_MAX   = 30,
  parameter int STB_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_opcode,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_col_vld,
  input  logic [PAGE_W-1:0] req_page,
  input  logic              req_page_vld,
  input  logic              cfg_bus16,
  input  logic              cfg_row3,
  input  logic              nand_rdy,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_ce_n,
  output logic              nand_we_n,
  output logic [15:0]       nand_dq_out,
  output logic              nand_dq_oe,
  output logic              done,
  output logic              timeout
);

  localparam int US_CYC  = CLK_MHZ;
  localparam int TWB_RAW = (TWB_NS * CLK_MHZ + 999) / 1000;
  localparam int TWB_CYC = (TWB_RAW < 1) ? 1 : TWB_RAW;
  localparam int TMR_W   = $clog2(US_CYC + TWB_CYC + 1);
  localparam int POLL_W  = $clog2(POLL_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_XFER, S_SETTLE, S_TWB, S_POLL, S_WAIT, S_FIN
  } state_e;

  state_e             state, state_d;
  seq_plan_t          plan_d, plan_q;
  logic [2:0]         idx;
  logic [POLL_W-1:0]  polls;
  logic               ce_hold;
  logic               timeout_q;

  // named internal events
  logic               accept;
  logic               slot_end;
  logic               stb_active;
  logic               xfer_last;
  logic               next_slot;
  logic               stb_start;
  logic               tmr_load;
  logic [TMR_W-1:0]   tmr_val;
  logic               tmr_zero;
  logic               fin_timeout;
  logic               going_fin;
  logic               hold_start;

  nand_seq_plan #(
    .COL_W(COL_W), .PAGE_W(PAGE_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_plan (
    .opcode(req_opcode), .col(req_col), .col_vld(req_col_vld),
    .page(req_page), .page_vld(req_page_vld),
    .bus16(cfg_bus16), .row3(cfg_row3), .plan(plan_d)
  );

  nand_we_strobe #(.STB_CYC(STB_CYC)) u_stb (
    .clk(clk), .rst_n(rst_n), .start(stb_start),
    .we_n(nand_we_n), .slot_end(slot_end), .active(stb_active)
  );

  nand_delay_tmr #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

  assign req_ready  = (state == S_IDLE);
  assign accept     = req_valid && req_ready;
  assign xfer_last  = (state == S_XFER) && slot_end && (idx == plan_q.count - 3'd1);
  assign next_slot  = (state == S_XFER) && slot_end && !xfer_last;
  assign stb_start  = accept || next_slot;
  assign hold_start = next_slot && plan_q.hold_en && ((idx + 3'd1) == plan_q.hold_idx);
  assign going_fin  = (state != S_FIN) && (state_d == S_FIN);

  always_comb begin
    state_d     = state;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    fin_timeout = 1'b0;
    unique case (state)
      S_IDLE: if (accept) state_d = S_XFER;
      S_XFER: begin
        if (xfer_last) begin
          if (plan_q.has_addr) begin
            state_d  = S_SETTLE;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(US_CYC - 1);
          end else if (plan_q.mode == WAIT_NONE) begin
            state_d = S_FIN;
          end else begin
            state_d  = S_TWB;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(TWB_CYC - 1);
          end
        end
      end
      S_SETTLE: begin
        if (tmr_zero) begin
          if (plan_q.mode == WAIT_NONE) begin
            state_d = S_FIN;
          end else begin
            state_d  = S_TWB;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(TWB_CYC - 1);
          end
        end
      end
      S_TWB: begin
        if (tmr_zero) begin
          if (plan_q.mode == WAIT_BOUNDED) begin
            state_d  = S_POLL;
            tmr_load = 1'b1;
            tmr_val  = '0;
          end else begin
            state_d = S_WAIT;
          end
        end
      end
      S_POLL: begin
        if (tmr_zero) begin
          if (nand_rdy) begin
            state_d = S_FIN;
          end else if (polls == POLL_W'(POLL_MAX)) begin
            state_d     = S_FIN;
            fin_timeout = 1'b1;
          end else begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(US_CYC - 1);
          end
        end
      end
      S_WAIT: if (nand_rdy) state_d = S_FIN;
      S_FIN:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      plan_q    <= '0;
      idx       <= '0;
      polls     <= '0;
      ce_hold   <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      state <= state_d;
      if (accept) begin
        plan_q    <= plan_d;
        idx       <= '0;
        polls     <= '0;
        timeout_q <= 1'b0;
      end
      if (next_slot) idx <= idx + 3'd1;
      if (state == S_POLL && tmr_zero && !nand_rdy && polls != POLL_W'(POLL_MAX))
        polls <= polls + 1'b1;
      if (going_fin)       ce_hold <= 1'b0;
      else if (hold_start) ce_hold <= 1'b1;
      if (going_fin && fin_timeout) timeout_q <= 1'b1;
    end
  end

  assign nand_cle    = (state == S_XFER) && !plan_q.is_addr[idx];
  assign nand_ale    = (state == S_XFER) &&  plan_q.is_addr[idx];
  assign nand_ce_n   = !(stb_active || ce_hold);
  assign nand_dq_oe  = (state == S_XFER);
  assign nand_dq_out = (state == S_XFER) ? {8'h00, plan_q.bytes[idx]} : 16'h0000;
  assign done        = (state == S_FIN);
  assign timeout     = timeout_q;

endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        nand_cle,
  input logic        nand_ale,
  input logic        nand_ce_n,
  input logic        nand_we_n,
  input logic [15:0] nand_dq_out,
  input logic        nand_dq_oe,
  input logic        done,
  input logic        timeout,
  input logic        ce_hold
);

  p_latch_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  p_strobe_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> (!nand_ce_n && nand_dq_oe));

  p_busy_after_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_idle_after_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);

  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_timeout_cleared_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !timeout);

  p_release_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_hold) |-> done);

  p_timeout_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);

  p_data_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> $stable(nand_dq_out));

endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_ce_n(nand_ce_n),
  .nand_we_n(nand_we_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
  .done(done), .timeout(timeout), .ce_hold(ce_hold)
);

// File: tb/test_nand_cmd_seq.sv
module test_nand_cmd_seq;

  localparam int US = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_opcode = '0;
  logic [11:0] req_col = '0;
  logic        req_col_vld = 1'b0;
  logic [19:0] req_page = '0;
  logic        req_page_vld = 1'b0;
  logic        cfg_bus16 = 1'b0;
  logic        cfg_row3 = 1'b0;
  logic        nand_rdy = 1'b0;
  logic        nand_cle, nand_ale, nand_ce_n, nand_we_n, nand_dq_oe, done, timeout;
  logic [15:0] nand_dq_out;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  int last_latch = 0;
  logic prev_we = 1'b1;

  bit        exp_a[$];
  bit [7:0]  exp_d[$];
  string     exp_t[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nand_cmd_seq i_nand_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_col(req_col), .req_col_vld(req_col_vld),
    .req_page(req_page), .req_page_vld(req_page_vld),
    .cfg_bus16(cfg_bus16), .cfg_row3(cfg_row3), .nand_rdy(nand_rdy),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_ce_n(nand_ce_n),
    .nand_we_n(nand_we_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .done(done), .timeout(timeout)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic push(input bit a, input bit [7:0] d, input string t);
    exp_a.push_back(a);
    exp_d.push_back(d);
    exp_t.push_back(t);
  endtask

  // expected latch list, built from the requirements
  task automatic expect_seq(input bit [7:0] op, input int col, input bit cv,
                            input int pg, input bit pv);
    int c = col;
    if (op == 8'h80) begin
      if (cv && col >= 512)      begin push(0, 8'h50, "R3"); c = col - 512; end
      else if (cv && col >= 256) begin push(0, 8'h01, "R3"); c = col - 256; end
      else                             push(0, 8'h00, "R3");
    end
    push(0, op, "R2");
    if (cv) begin
      if (cfg_bus16 && !(op inside {8'h90, 8'hEC, 8'hEE, 8'hEF})) c = c / 2;
      push(1, 8'(c), "R5");
    end
    if (pv) begin
      push(1, 8'(pg), "R4");
      push(1, 8'(pg >> 8), "R4");
      if (cfg_row3) push(1, {4'h0, 4'(pg >> 16)}, "R4");
    end
  endtask

  // monitor: compare each latched byte against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !prev_we && nand_we_n) begin
      last_latch = cyc;
      if (exp_d.size() == 0) begin
        check(1'b0, "R6", "unexpected latch", int'(nand_dq_out), -1);
      end else begin
        bit a;
        bit [7:0] d;
        string t;
        a = exp_a.pop_front();
        d = exp_d.pop_front();
        t = exp_t.pop_front();
        check(nand_ale == a && nand_cle == !a, a ? "R4" : "R2", "latch phase",
              int'({nand_cle, nand_ale}), a ? 1 : 2);
        check(nand_dq_out == {8'h00, d}, t, "latched byte", int'(nand_dq_out), int'(d));
        check(!nand_ce_n, "R2", "ce_n at latch", int'(nand_ce_n), 0);
      end
    end
    prev_we = nand_we_n;
  end

  task automatic issue(input bit [7:0] op, input int col, input bit cv,
                       input int pg, input bit pv);
    expect_seq(op, col, cv, pg, pv);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid    = 1'b1;
    req_opcode   = op;
    req_col      = 12'(col);
    req_col_vld  = cv;
    req_page     = 20'(pg);
    req_page_vld = pv;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R1", "ready after accept", int'(req_ready), 0);
  endtask

  task automatic drain;
    while (exp_d.size() != 0) @(negedge clk);
  endtask

  task automatic wait_done(output int dcyc);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    dcyc = cyc;
    check(done == 1'b1, "R12", "done seen", int'(done), 1);
    check(exp_d.size() == 0, "R2", "bytes left at done", exp_d.size(), 0);
  endtask

  task automatic after_done(input bit exp_to);
    check(timeout == exp_to, exp_to ? "R9" : "R10", "timeout at done", int'(timeout), int'(exp_to));
    check(nand_ce_n, "R8", "ce released at done", int'(nand_ce_n), 1);
    @(negedge clk);
    check(!done, "R12", "done single cycle", int'(done), 0);
    check(timeout == exp_to, "R12", "timeout held", int'(timeout), int'(exp_to));
    check(req_ready, "R1", "ready after done", int'(req_ready), 1);
  endtask

  initial begin
    int dc;
    int delta;
    bit seen;
    repeat (3) @(negedge clk);
    check(req_ready && nand_ce_n && !nand_cle && !nand_ale && nand_we_n && !done && !timeout,
          "R1", "reset outputs", int'({req_ready, nand_ce_n, nand_we_n}), 7);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_ready, "R1", "idle ready", int'(req_ready), 1);

    // status, no address: immediate, ready ignored (R6, R7)
    issue(8'h70, 0, 0, 0, 0);
    wait_done(dc);
    delta = dc - last_latch;
    check(delta >= 1 && delta <= 10, "R7", "status completion delay", delta, 3);
    after_done(1'b0);

    // program setup, column 100 -> pointer 0x00 (R3, R4, R7, R11)
    issue(8'h80, 100, 1, 20'h12345, 1);
    drain();
    repeat (20) @(negedge clk);
    check(nand_ce_n, "R8", "no hold on program setup", int'(nand_ce_n), 1);
    wait_done(dc);
    delta = dc - last_latch;
    check(delta >= US && delta <= US + 10, "R11", "settle before done", delta, US + 2);
    after_done(1'b0);

    // column 300 -> pointer 0x01, three row bytes (R3, R4)
    cfg_row3 = 1'b1;
    issue(8'h80, 300, 1, 20'hABCDE, 1);
    wait_done(dc);
    after_done(1'b0);

    // column 520 on a 16-bit bus -> pointer 0x50, column 8 halved (R3, R5)
    cfg_row3  = 1'b0;
    cfg_bus16 = 1'b1;
    issue(8'h80, 520, 1, 20'h00033, 1);
    wait_done(dc);
    after_done(1'b0);

    // id-type opcode keeps byte column on 16-bit bus, unbounded wait (R5, R10)
    nand_rdy = 1'b1;
    issue(8'h90, 8'h20, 1, 0, 0);
    wait_done(dc);
    after_done(1'b0);
    nand_rdy = 1'b0;

    // read with page, ready never comes: hold ce, time out (R8, R9)
    issue(8'h00, 8'h40, 1, 20'h00102, 1);
    drain();
    repeat (300) @(negedge clk);
    check(!nand_ce_n, "R8", "ce held during read wait", int'(nand_ce_n), 0);
    check(!nand_cle && !nand_ale, "R8", "latches low during wait", int'({nand_cle, nand_ale}), 0);
    wait_done(dc);
    delta = dc - last_latch;
    check(delta >= US + 5 + 30 * US && delta <= US + 5 + 30 * US + 20, "R9",
          "bounded wait length", delta, US + 5 + 30 * US + 2);
    after_done(1'b1);

    // read-oob with page, ready arrives mid-wait (R9, R12)
    cfg_bus16 = 1'b0;
    cfg_row3  = 1'b1;
    issue(8'h50, 5, 1, 20'h7F00F, 1);
    drain();
    repeat (300) @(negedge clk);
    check(!nand_ce_n, "R8", "ce held before ready", int'(nand_ce_n), 0);
    nand_rdy = 1'b1;
    delta = cyc;
    wait_done(dc);
    check(dc - delta <= US + 3, "R9", "completion after ready", dc - delta, US);
    after_done(1'b0);
    nand_rdy = 1'b0;

    // reset opcode waits without limit (R10)
    issue(8'hFF, 0, 0, 0, 0);
    seen = 1'b0;
    for (int i = 0; i < 2500; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    check(!seen, "R10", "reset still waiting", int'(seen), 0);
    check(nand_ce_n, "R8", "no hold on reset", int'(nand_ce_n), 1);
    nand_rdy = 1'b1;
    delta = cyc;
    wait_done(dc);
    check(dc - delta <= 3, "R10", "reset completion after ready", dc - delta, 1);
    after_done(1'b0);
    nand_rdy = 1'b0;

    // erase setup with page only, no ready wait (R7, R4)
    issue(8'h60, 0, 0, 20'h5A5A5, 1);
    wait_done(dc);
    delta = dc - last_latch;
    check(delta >= US && delta <= US + 10, "R7", "erase setup completion", delta, US + 2);
    after_done(1'b0);

    // read without page: unbounded wait, no timeout (R10)
    cfg_row3 = 1'b0;
    issue(8'h01, 7, 1, 0, 0);
    seen = 1'b0;
    for (int i = 0; i < 1800; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    check(!seen, "R10", "pageless read waits", int'(seen), 0);
    nand_rdy = 1'b1;
    wait_done(dc);
    after_done(1'b0);
    nand_rdy = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL R1 watchdog expired: actual %0d cycles expected fewer", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule